// File: doc/BRIEF.md
# Capability Record List Walker

This block scans a chain of type-length-value capability records held in an 8 KiB word-addressed configuration memory and pulls out the few settings the rest of the chip needs. A single start pulse launches the scan at byte offset 0x0058. The walker reads one 32-bit header, decides from its type whether to skip the payload, capture it or abort, and then moves to the next header. The scan stops at an end record, or it stops on an error.

The walker captures two things: the engine clock frequency in MHz, and the byte offset and length of a mailbox area. When the list has no mailbox record, the mailbox outputs hold the defaults 0x1800 and 0x1F8. Memory is read through a simple synchronous port whose data arrives one cycle after the request. When the walk ends, `done_o` pulses for one cycle. `err_o` pulses in the same cycle if the walk failed. The captured values then hold until the next start.

Top module: `tlv_walker`

## Requirements
- R1: After reset, busy_o, done_o, err_o and mem_rd_en_o are low, freq_o is 0, mbox_off_o is 0x1800 and mbox_len_o is 0x1F8.
- R2: If the word at byte offset 0x0058 is zero, the walk ends with done_o, no err_o, and the default mailbox and frequency values.
- R3: A header word holds the must-understand flag in bit 31, the type in bits 30:16 and the payload byte length in bits 15:0. The next header is at header offset + 4 + length. Type 1 records, and records of an unknown type with bit 31 clear, are skipped without looking inside their payload.
- R4: A type 2 record ends the walk with done_o and no err_o.
- R5: A type 3 record with length 4 loads freq_o from the word that follows its header. A type 3 record of any other length is an error.
- R6: A type 4 record sets mbox_off_o to the header offset + 4 and mbox_len_o to the record length.
- R7: A header of type 0 that is not an all-zero first word is an error.
- R8: A header of an unknown type with bit 31 set is an error.
- R9: A length that is not a multiple of 4 is an error.
- R10: A record whose payload would end past byte 0x2000 is an error. A header that would itself start at or past 0x2000 is also an error. A record that ends exactly at 0x1FFC, followed by an end record there, is accepted.
- R11: busy_o is high from the cycle after an accepted start until the walk ends. done_o pulses for exactly one cycle, and busy_o is low in that cycle. err_o is high only together with done_o. A start while busy is ignored.
- R12: Each accepted start restores the default frequency and mailbox values. The captured values do not change while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a walk when idle |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk ends |
| err_o | output | 1 | One-cycle pulse with done_o when the walk failed |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_addr_o | output | 11 | Memory word address |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| freq_o | output | 32 | Captured clock frequency in MHz |
| mbox_off_o | output | 16 | Mailbox byte offset |
| mbox_len_o | output | 16 | Mailbox byte length |

## Verification
A wrong cursor value shows up quickly at the ports. The walker lands inside a payload and reads data as a header, which usually turns into an error pulse or a wrong capture within a few cycles of the bad step. The stimulus therefore hides tempting words (type 0, mandatory unknown, frequency headers) inside skipped payloads. A misordered decode check, such as testing the bounds before the length alignment, can only show through err_o on the records built to sit on those edges, so each error class has its own single-fault list. Stale capture state shows on the first walk after a run that filled the registers.

// File: rtl/tlv_walk_pkg.sv
package tlv_walk_pkg;

  // Outcome of decoding one record header
  typedef enum logic [2:0] {
    VD_ABSENT,
    VD_ERR,
    VD_END,
    VD_SKIP,
    VD_FREQ,
    VD_MBOX
  } verdict_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_RD,
    ST_HDR_WT,
    ST_PAY_RD,
    ST_PAY_WT
  } walk_state_e;

  localparam logic [14:0] TY_INVALID = 15'd0;
  localparam logic [14:0] TY_PAD     = 15'd1;
  localparam logic [14:0] TY_END     = 15'd2;
  localparam logic [14:0] TY_FREQ    = 15'd3;
  localparam logic [14:0] TY_MBOX    = 15'd4;

  localparam int HDR_BYTES = 4;

endpackage

// File: rtl/tlv_hdr_decode.sv
module tlv_hdr_decode
  import tlv_walk_pkg::*;
#(
  parameter int SUM_W       = 18,
  parameter int SPACE_BYTES = 8192
) (
  input  logic [31:0]      hdr_i,
  input  logic             first_i,
  input  logic [SUM_W-1:0] pos_i,
  output verdict_e         verdict_o,
  output logic [SUM_W-1:0] next_pos_o
);

  logic        must_know;
  logic [14:0] rec_type;
  logic [15:0] rec_len;

  assign must_know  = hdr_i[31];
  assign rec_type   = hdr_i[30:16];
  assign rec_len    = hdr_i[15:0];
  assign next_pos_o = pos_i + SUM_W'(HDR_BYTES) + SUM_W'(rec_len);

  always_comb begin
    if (first_i && (hdr_i == 32'd0)) begin
      verdict_o = VD_ABSENT;
    end else if (rec_type == TY_INVALID) begin
      verdict_o = VD_ERR;
    end else if (rec_len[1:0] != 2'b00) begin
      verdict_o = VD_ERR;
    end else if (next_pos_o > SUM_W'(SPACE_BYTES)) begin
      verdict_o = VD_ERR;
    end else begin
      case (rec_type)
        TY_END:  verdict_o = VD_END;
        TY_FREQ: verdict_o = (rec_len == 16'd4) ? VD_FREQ : VD_ERR;
        TY_MBOX: verdict_o = VD_MBOX;
        TY_PAD:  verdict_o = VD_SKIP;
        default: verdict_o = must_know ? VD_ERR : VD_SKIP;
      endcase
    end
  end

endmodule

// File: rtl/tlv_capture_regs.sv
module tlv_capture_regs #(
  parameter int              FREQ_W  = 32,
  parameter int              OFF_W   = 16,
  parameter int              LEN_W   = 16,
  parameter logic [OFF_W-1:0] DEF_OFF = 16'h1800,
  parameter logic [LEN_W-1:0] DEF_LEN = 16'h01F8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              freq_we_i,
  input  logic [FREQ_W-1:0] freq_d_i,
  input  logic              mbox_we_i,
  input  logic [OFF_W-1:0]  off_d_i,
  input  logic [LEN_W-1:0]  len_d_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [LEN_W-1:0]  len_o
);

  logic [FREQ_W-1:0] freq_d;
  logic [OFF_W-1:0]  off_d;
  logic [LEN_W-1:0]  len_d;
  logic              cap_en;

  assign cap_en = clear_i | freq_we_i | mbox_we_i;

  always_comb begin
    freq_d = freq_o;
    off_d  = off_o;
    len_d  = len_o;
    if (clear_i) begin
      freq_d = '0;
      off_d  = DEF_OFF;
      len_d  = DEF_LEN;
    end else begin
      if (freq_we_i) freq_d = freq_d_i;
      if (mbox_we_i) begin
        off_d = off_d_i;
        len_d = len_d_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_o <= '0;
      off_o  <= DEF_OFF;
      len_o  <= DEF_LEN;
    end else if (cap_en) begin
      freq_o <= freq_d;
      off_o  <= off_d;
      len_o  <= len_d;
    end
  end

endmodule

// File: rtl/tlv_walker.sv
module tlv_walker
  import tlv_walk_pkg::*;
#(
  parameter int SPACE_BYTES  = 8192,
  parameter int LIST_BASE    = 'h58,
  parameter int MBOX_DEF_OFF = 'h1800,
  parameter int MBOX_DEF_LEN = 'h1F8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic        mem_rd_en_o,
  output logic [$clog2(SPACE_BYTES)-3:0] mem_addr_o,
  input  logic [31:0] mem_rdata_i,
  output logic [31:0] freq_o,
  output logic [15:0] mbox_off_o,
  output logic [15:0] mbox_len_o
);

  localparam int BYTE_W = $clog2(SPACE_BYTES);
  localparam int WA_W   = BYTE_W - 2;
  localparam int SUM_W  = ((BYTE_W > 16) ? BYTE_W : 16) + 2;

  walk_state_e      state_q, state_d;
  logic [SUM_W-1:0] pos_q, pos_d;
  logic             first_q, first_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             clear, freq_we, mbox_we;
  verdict_e         verdict;
  logic [SUM_W-1:0] next_pos;

  tlv_hdr_decode #(
    .SUM_W       (SUM_W),
    .SPACE_BYTES (SPACE_BYTES)
  ) u_dec (
    .hdr_i      (mem_rdata_i),
    .first_i    (first_q),
    .pos_i      (pos_q),
    .verdict_o  (verdict),
    .next_pos_o (next_pos)
  );

  tlv_capture_regs #(
    .FREQ_W  (32),
    .OFF_W   (16),
    .LEN_W   (16),
    .DEF_OFF (16'(MBOX_DEF_OFF)),
    .DEF_LEN (16'(MBOX_DEF_LEN))
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear),
    .freq_we_i (freq_we),
    .freq_d_i  (mem_rdata_i),
    .mbox_we_i (mbox_we),
    .off_d_i   (16'(pos_q + SUM_W'(HDR_BYTES))),
    .len_d_i   (mem_rdata_i[15:0]),
    .freq_o    (freq_o),
    .off_o     (mbox_off_o),
    .len_o     (mbox_len_o)
  );

  always_comb begin
    state_d     = state_q;
    pos_d       = pos_q;
    first_d     = first_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    clear       = 1'b0;
    freq_we     = 1'b0;
    mbox_we     = 1'b0;
    mem_rd_en_o = 1'b0;
    mem_addr_o  = pos_q[BYTE_W-1:2];
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          clear   = 1'b1;
          pos_d   = SUM_W'(LIST_BASE);
          first_d = 1'b1;
          state_d = ST_HDR_RD;
        end
      end
      ST_HDR_RD: begin
        if (pos_q > SUM_W'(SPACE_BYTES - HDR_BYTES)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else begin
          mem_rd_en_o = 1'b1;
          state_d     = ST_HDR_WT;
        end
      end
      ST_HDR_WT: begin
        first_d = 1'b0;
        case (verdict)
          VD_ABSENT, VD_END: begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
          VD_SKIP: begin
            pos_d   = next_pos;
            state_d = ST_HDR_RD;
          end
          VD_MBOX: begin
            mbox_we = 1'b1;
            pos_d   = next_pos;
            state_d = ST_HDR_RD;
          end
          VD_FREQ: state_d = ST_PAY_RD;
          default: begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
          end
        endcase
      end
      ST_PAY_RD: begin
        mem_rd_en_o = 1'b1;
        mem_addr_o  = pos_q[BYTE_W-1:2] + WA_W'(1);
        state_d     = ST_PAY_WT;
      end
      ST_PAY_WT: begin
        freq_we = 1'b1;
        pos_d   = pos_q + SUM_W'(2 * HDR_BYTES);
        state_d = ST_HDR_RD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      first_q <= first_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/tlv_walker_chk.sv
module tlv_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        mem_rd_en_o,
  input logic [31:0] freq_o,
  input logic [15:0] mbox_off_o,
  input logic [15:0] mbox_len_o
);

  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_start_accepted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_read_in_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |-> busy_o);

  assert_read_then_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> (busy_o && !mem_rd_en_o));

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(freq_o) && $stable(mbox_off_o) && $stable(mbox_len_o)));

endmodule

bind tlv_walker tlv_walker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .mem_rd_en_o (mem_rd_en_o),
  .freq_o      (freq_o),
  .mbox_off_o  (mbox_off_o),
  .mbox_len_o  (mbox_len_o)
);

// File: tb/tlv_walker_bench.sv
module tlv_walker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 2048;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        busy_o, done_o, err_o, mem_rd_en_o;
  logic [10:0] mem_addr_o;
  logic [31:0] mem_rdata_i;
  logic [31:0] freq_o;
  logic [15:0] mbox_off_o, mbox_len_o;

  logic [31:0] mem [0:WORDS-1];

  int checks;
  int fails;
  logic last_err;

  tlv_walker u_tlv_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .mem_rd_en_o (mem_rd_en_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .freq_o      (freq_o),
    .mbox_off_o  (mbox_off_o),
    .mbox_len_o  (mbox_len_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd_en_o) mem_rdata_i <= mem[mem_addr_o];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < WORDS; i++) mem[i] = 32'd0;
  endtask

  task automatic put(input int byte_addr, input logic [31:0] val);
    mem[byte_addr >> 2] = val;
  endtask

  // Launch a walk, optionally re-pulse start while busy, wait for done
  task automatic run_walk(input bit poke);
    int waited;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R11 busy after start", 32'(busy_o), 32'd1);
    if (poke) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(done_o == 1'b1, "R11 done reached", 32'(done_o), 32'd1);
    check(busy_o == 1'b0, "R11 idle at done", 32'(busy_o), 32'd0);
    last_err = err_o;
    @(negedge clk);
    check({done_o, err_o} == 2'b00, "R11 one-cycle pulse", 32'({done_o, err_o}), 32'd0);
  endtask

  task automatic expect_result(input string req, input bit exp_err, input logic [31:0] exp_freq,
                               input logic [15:0] exp_off, input logic [15:0] exp_len);
    check(last_err == exp_err, {req, " error flag"}, 32'(last_err), 32'(exp_err));
    check(freq_o == exp_freq, {req, " frequency"}, freq_o, exp_freq);
    check(mbox_off_o == exp_off, {req, " mailbox offset"}, 32'(mbox_off_o), 32'(exp_off));
    check(mbox_len_o == exp_len, {req, " mailbox length"}, 32'(mbox_len_o), 32'(exp_len));
  endtask

  task automatic t_reset();
    check({busy_o, done_o, err_o, mem_rd_en_o} == 4'b0, "R1 control outputs", 32'({busy_o, done_o, err_o, mem_rd_en_o}), 32'd0);
    check(freq_o == 32'd0, "R1 frequency", freq_o, 32'd0);
    check(mbox_off_o == 16'h1800, "R1 mailbox offset", 32'(mbox_off_o), 32'h1800);
    check(mbox_len_o == 16'h01F8, "R1 mailbox length", 32'(mbox_len_o), 32'h1F8);
  endtask

  task automatic t_absent();
    clear_mem();
    run_walk(1'b0);
    expect_result("R2 absent list", 1'b0, 32'd0, 16'h1800, 16'h01F8);
  endtask

  task automatic t_capture();
    clear_mem();
    put('h58, 32'h0003_0004);
    put('h5C, 32'd100);
    put('h60, 32'h0004_0040);
    put('h64, 32'h0000_0000);
    put('hA4, 32'h0002_0000);
    run_walk(1'b1);
    expect_result("R5 R6 R4 capture", 1'b0, 32'd100, 16'h0064, 16'h0040);
    repeat (5) @(negedge clk);
    check(freq_o == 32'd100, "R12 idle hold frequency", freq_o, 32'd100);
    check(mbox_off_o == 16'h0064, "R12 idle hold offset", 32'(mbox_off_o), 32'h64);
  endtask

  task automatic t_skip();
    clear_mem();
    put('h58, 32'h0001_0008);
    put('h5C, 32'h0000_0000);
    put('h60, 32'h8099_0000);
    put('h64, 32'h0123_0004);
    put('h68, 32'h0003_0004);
    put('h6C, 32'h0002_0000);
    run_walk(1'b0);
    expect_result("R3 R12 skip and defaults", 1'b0, 32'd0, 16'h1800, 16'h01F8);
  endtask

  task automatic t_type0();
    clear_mem();
    put('h58, 32'h0001_0000);
    put('h5C, 32'h0000_0000);
    run_walk(1'b0);
    check(last_err == 1'b1, "R7 type 0 error", 32'(last_err), 32'd1);
  endtask

  task automatic t_mandatory();
    clear_mem();
    put('h58, 32'h8007_0004);
    put('h60, 32'h0002_0000);
    run_walk(1'b0);
    check(last_err == 1'b1, "R8 mandatory unknown", 32'(last_err), 32'd1);
  endtask

  task automatic t_misaligned();
    clear_mem();
    put('h58, 32'h0001_0006);
    put('h60, 32'h0002_0000);
    run_walk(1'b0);
    check(last_err == 1'b1, "R9 misaligned length", 32'(last_err), 32'd1);
  endtask

  task automatic t_freq_len();
    clear_mem();
    put('h58, 32'h0003_0008);
    put('h5C, 32'd55);
    put('h64, 32'h0002_0000);
    run_walk(1'b0);
    check(last_err == 1'b1, "R5 bad frequency length", 32'(last_err), 32'd1);
    check(freq_o == 32'd0, "R5 no frequency capture", freq_o, 32'd0);
  endtask

  task automatic t_bounds();
    clear_mem();
    put('h58, 32'h0001_1FA8);
    run_walk(1'b0);
    check(last_err == 1'b1, "R10 past space end", 32'(last_err), 32'd1);
    clear_mem();
    put('h58, 32'h0001_1FA4);
    run_walk(1'b0);
    check(last_err == 1'b1, "R10 header at space end", 32'(last_err), 32'd1);
    clear_mem();
    put('h58, 32'h0001_1FA0);
    put('h1FFC, 32'h0002_0000);
    run_walk(1'b0);
    check(last_err == 1'b0, "R10 fits to last word", 32'(last_err), 32'd0);
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    last_err = 1'b0;
    start_i  = 1'b0;
    rst_n    = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_absent();
    t_capture();
    t_skip();
    t_type0();
    t_mandatory();
    t_misaligned();
    t_freq_len();
    t_bounds();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule